// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the command side of a parallel NOR flash device in front of a small on-chip word array that stands in for the cell matrix. A host issues single-cycle write strobes, each carrying an address and a data word, and single-cycle read strobes. The controller decodes multi-cycle unlock sequences from those writes. It then runs timed internal word-program and sector-erase operations against the array.

While an operation runs, the `ready` output is low. Reads then return a status word instead of array data: a polling bit that shows the complement of the value being written, and a bit that flips on every read. A shortened two-write program mode is available for bulk loading. A running erase can be paused so that the other sectors can be read or programmed, and then resumed. Sectors can be write-locked through an input vector. An active-low reset abandons any operation and returns to array reads.

Operation lengths are parameters counted in clock cycles. The array size and the sector count are also parameters.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A program needs four writes: 0xAA at address 0x555, 0x55 at address 0x2AA, 0xA0 at address 0x555, and then the target address with the data. Only the low 11 address bits are compared, and the array word is `addr[MEM_AW-1:0]`. The stored word becomes the bitwise AND of the old word and the new data.
- R2: `ready` goes low on the clock edge that accepts a program and stays low for exactly PROG_CYC cycles.
- R3: A read issued while `ready` is low returns a status word one cycle later. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 6 is inverted relative to the previous status read. All other bits are 0. Once the operation ends, reads return array data again.
- R4: A write that breaks an unlock sequence (wrong data or wrong address) drops the controller back to read mode, and the next write starts no operation.
- R5: Writes arriving while `ready` is low are ignored, except 0xB0 during an erase.
- R6: Writing 0x20 as the third cycle enters bypass mode. In that mode, 0xA0 followed by address and data programs a word in two writes. The writes 0x90 then 0x00 leave bypass mode, after which two-write programs no longer act.
- R7: `lock[i]` protects sector i, where the sector is `addr[MEM_AW-1:MEM_AW-SEC_AW]`. A program or erase aimed at a locked sector leaves `ready` high and the array unchanged.
- R8: A sector erase is the writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the sector. Afterwards every word of that sector reads all ones, and every other sector is unchanged.
- R9: An erase first zeroes the sector unless every word of it is already zero. `ready` is low for PRE_CYC+ERS_CYC cycles in the first case and ERS_CYC cycles in the second.
- R10: Writing 0xB0 during an erase suspends it and `ready` returns high. While suspended, other sectors read as array data and accept programs. Reads inside the suspended sector return a status word with bit 7 = 0 and all bits other than 6 at 0. Programs into the suspended sector are ignored.
- R11: Writing 0x30 while suspended resumes the erase. `ready` drops low and the erase completes with the sector reading all ones.
- R12: Asserting `rst_n` low aborts a running program without storing its data, returns to read mode, and leaves bypass mode.
- R13: After power-up `ready` is high and every array word reads all ones. 0xF0 clears a partly entered sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we | input | 1 | Write strobe, one bus write per high cycle |
| re | input | 1 | Read strobe, data appears on `rdata` after the next edge |
| addr | input | ADDR_W | Bus address for reads, commands and targets |
| wdata | input | DATA_W | Write data / command code |
| lock | input | 2**SEC_AW | Per-sector write protection |
| rdata | output | DATA_W | Registered read data or status word |
| ready | output | 1 | Low while an internal program or erase runs |

## Verification
The bench targets the points where sequence decoding is easiest to get wrong. It breaks an unlock sequence part-way, then writes a lone data word that a lax decoder would program. It sends a full unlock sequence during a busy period, which a decoder that fails to ignore busy writes would leave armed. It uses the bypass exit, which would leave two-write programming live if mishandled. Busy-window lengths are measured for programs and for erases of partly written and fully zeroed sectors, so a missing or unconditional pre-zeroing pass shows up as a wrong cycle count. Suspend is exercised with reads and programs on both sides of the sector boundary, followed by resume. A final sweep of the whole array against a bench model exposes any erase that spills into a neighbouring sector, or any aborted or locked program that left a mark.

// File: rtl/nor_fc_pkg.sv
package nor_fc_pkg;

   typedef enum logic [3:0] {
      D_RD, D_C1, D_C2, D_PGM, D_ES1, D_ES2, D_ES3, D_BYP, D_BPGM, D_BEXIT
   } dec_st_t;

   typedef enum logic [2:0] {
      E_IDLE, E_PROG, E_PRE, E_ERASE, E_SUSP
   } eng_st_t;

   localparam logic [10:0] ADR_A = 11'h555;
   localparam logic [10:0] ADR_B = 11'h2AA;

   localparam logic [7:0] K_UNLK1 = 8'hAA;
   localparam logic [7:0] K_UNLK2 = 8'h55;
   localparam logic [7:0] K_PROG  = 8'hA0;
   localparam logic [7:0] K_ESET  = 8'h80;
   localparam logic [7:0] K_BYP   = 8'h20;
   localparam logic [7:0] K_SUSP  = 8'hB0;
   localparam logic [7:0] K_GO    = 8'h30;
   localparam logic [7:0] K_CLR   = 8'hF0;
   localparam logic [7:0] K_BEX1  = 8'h90;
   localparam logic [7:0] K_BEX2  = 8'h00;

endpackage

// File: rtl/nor_fc_decode.sv
module nor_fc_decode
   import nor_fc_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              blocked,
   input  logic              suspended,
   output logic              req_prog,
   output logic              req_ers,
   output logic              req_susp,
   output logic              req_resume
);

   dec_st_t    st, nxt;
   logic [7:0] c;
   logic       at_a, at_b, in_byp;

   assign c      = wdata[7:0];
   assign at_a   = (addr[10:0] == ADR_A);
   assign at_b   = (addr[10:0] == ADR_B);
   assign in_byp = (st == D_BYP) || (st == D_BPGM) || (st == D_BEXIT);

   always_comb begin
      nxt        = st;
      req_prog   = 1'b0;
      req_ers    = 1'b0;
      req_susp   = 1'b0;
      req_resume = 1'b0;
      if (we) begin
         if (blocked) begin
            req_susp = (c == K_SUSP);
         end else if (c == K_CLR && st != D_PGM && st != D_BPGM) begin
            nxt = in_byp ? D_BYP : D_RD;
         end else begin
            unique case (st)
               D_RD: begin
                  if (suspended && c == K_GO) req_resume = 1'b1;
                  else if (c == K_UNLK1 && at_a) nxt = D_C1;
               end
               D_C1:  nxt = (c == K_UNLK2 && at_b) ? D_C2 : D_RD;
               D_C2: begin
                  nxt = D_RD;
                  if (at_a) begin
                     if (c == K_PROG) nxt = D_PGM;
                     else if (c == K_ESET && !suspended) nxt = D_ES1;
                     else if (c == K_BYP) nxt = D_BYP;
                  end
               end
               D_PGM: begin
                  req_prog = 1'b1;
                  nxt      = D_RD;
               end
               D_ES1: nxt = (c == K_UNLK1 && at_a) ? D_ES2 : D_RD;
               D_ES2: nxt = (c == K_UNLK2 && at_b) ? D_ES3 : D_RD;
               D_ES3: begin
                  req_ers = (c == K_GO);
                  nxt     = D_RD;
               end
               D_BYP: begin
                  if (suspended && c == K_GO) req_resume = 1'b1;
                  else if (c == K_PROG) nxt = D_BPGM;
                  else if (c == K_BEX1) nxt = D_BEXIT;
               end
               D_BPGM: begin
                  req_prog = 1'b1;
                  nxt      = D_BYP;
               end
               D_BEXIT: nxt = (c == K_BEX2) ? D_RD : D_BYP;
               default: nxt = D_RD;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= D_RD;
      else        st <= nxt;
   end

   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && blocked) |=> $stable(st));

endmodule

// File: rtl/nor_fc_engine.sv
module nor_fc_engine
   import nor_fc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MEM_AW   = 6,
   parameter int SEC_AW   = 2,
   parameter int PROG_CYC = 6,
   parameter int PRE_CYC  = 10,
   parameter int ERS_CYC  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_prog,
   input  logic                  req_ers,
   input  logic                  req_susp,
   input  logic                  req_resume,
   input  logic [MEM_AW-1:0]     a,
   input  logic [DATA_W-1:0]     d,
   input  logic [2**SEC_AW-1:0]  lock,
   output logic [DATA_W-1:0]     rd_word,
   output logic                  busy,
   output logic                  suspended,
   output logic                  prog_run,
   output logic                  pbit7,
   output logic [SEC_AW-1:0]     esec
);

   localparam int DEPTH  = 2**MEM_AW;
   localparam int OFF_W  = MEM_AW - SEC_AW;
   localparam int SWORDS = 2**OFF_W;
   localparam int EMAX   = (PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC;
   localparam int PW     = $clog2(PROG_CYC + 1);
   localparam int EW     = $clog2(EMAX + 1);

   eng_st_t             st;
   logic [PW-1:0]       pcnt;
   logic [EW-1:0]       ecnt;
   logic [MEM_AW-1:0]   pa;
   logic [DATA_W-1:0]   pd;
   logic                ephase, in_susp;
   logic [SEC_AW-1:0]   asec;
   logic                zsec, commit, wipe;
   logic [DATA_W-1:0]   fill;
   logic [DATA_W-1:0]   mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '1;
   end

   assign asec = a[MEM_AW-1:OFF_W];

   always_comb begin
      zsec = 1'b1;
      for (int i = 0; i < SWORDS; i++)
         if (mem[{asec, OFF_W'(i)}] != '0) zsec = 1'b0;
   end

   assign commit = (st == E_PROG) && (pcnt == '0);
   assign wipe   = (st == E_PRE || st == E_ERASE) && (ecnt == '0) && !req_susp;
   assign fill   = (st == E_ERASE) ? '1 : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= E_IDLE;
         pcnt    <= '0;
         ecnt    <= '0;
         pa      <= '0;
         pd      <= '0;
         esec    <= '0;
         ephase  <= 1'b0;
         in_susp <= 1'b0;
      end else begin
         unique case (st)
            E_IDLE: begin
               if (req_prog && !lock[asec]) begin
                  st      <= E_PROG;
                  pa      <= a;
                  pd      <= d;
                  pcnt    <= PW'(PROG_CYC - 1);
                  in_susp <= 1'b0;
               end else if (req_ers && !lock[asec]) begin
                  esec   <= asec;
                  ephase <= zsec;
                  st     <= zsec ? E_ERASE : E_PRE;
                  ecnt   <= zsec ? EW'(ERS_CYC - 1) : EW'(PRE_CYC - 1);
               end
            end
            E_PROG: begin
               if (pcnt == '0) st <= in_susp ? E_SUSP : E_IDLE;
               else            pcnt <= pcnt - 1'b1;
            end
            E_PRE, E_ERASE: begin
               if (req_susp) begin
                  st <= E_SUSP;
               end else if (ecnt == '0) begin
                  if (st == E_PRE) begin
                     st     <= E_ERASE;
                     ephase <= 1'b1;
                     ecnt   <= EW'(ERS_CYC - 1);
                  end else begin
                     st <= E_IDLE;
                  end
               end else begin
                  ecnt <= ecnt - 1'b1;
               end
            end
            E_SUSP: begin
               if (req_resume) begin
                  st <= ephase ? E_ERASE : E_PRE;
               end else if (req_prog && !lock[asec] && asec != esec) begin
                  st      <= E_PROG;
                  pa      <= a;
                  pd      <= d;
                  pcnt    <= PW'(PROG_CYC - 1);
                  in_susp <= 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++)
         if (wipe && esec == SEC_AW'(i >> OFF_W)) mem[i] <= fill;
      if (commit) mem[pa] <= mem[pa] & pd;
   end

   assign rd_word   = mem[a];
   assign busy      = (st == E_PROG) || (st == E_PRE) || (st == E_ERASE);
   assign suspended = (st == E_SUSP);
   assign prog_run  = (st == E_PROG);
   assign pbit7     = pd[7];

   // R1
   and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ((mem[pa] & ~$past(mem[pa])) == '0));

   // R7
   lock_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_IDLE && lock[asec] && (req_prog || req_ers)) |=> (st == E_IDLE));

   // R11
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_SUSP && req_resume) |=> (st == E_PRE || st == E_ERASE));

   // R2
   prog_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_PROG) |-> (pcnt < PW'(PROG_CYC)));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
   import nor_fc_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int DATA_W   = 8,
   parameter int MEM_AW   = 6,
   parameter int SEC_AW   = 2,
   parameter int PROG_CYC = 6,
   parameter int PRE_CYC  = 10,
   parameter int ERS_CYC  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic                  re,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [2**SEC_AW-1:0]  lock,
   output logic [DATA_W-1:0]     rdata,
   output logic                  ready
);

   localparam int OFF_W = MEM_AW - SEC_AW;

   if (DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W < 11) begin : g_bad_aw
      $error("ADDR_W must be at least 11");
   end
   if (MEM_AW > ADDR_W || SEC_AW < 1 || SEC_AW >= MEM_AW) begin : g_bad_geo
      $error("array geometry out of range");
   end
   if (PROG_CYC < 1 || PRE_CYC < 1 || ERS_CYC < 1) begin : g_bad_cyc
      $error("operation lengths must be at least one cycle");
   end

   logic                 req_prog, req_ers, req_susp, req_resume;
   logic                 busy, suspended, prog_run, pbit7;
   logic [SEC_AW-1:0]    esec;
   logic [DATA_W-1:0]    rd_word, st_word, sus_word;
   logic                 tog;

   nor_fc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
      .blocked(busy), .suspended(suspended),
      .req_prog(req_prog), .req_ers(req_ers),
      .req_susp(req_susp), .req_resume(req_resume)
   );

   nor_fc_engine #(
      .DATA_W(DATA_W), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW),
      .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .req_prog(req_prog), .req_ers(req_ers),
      .req_susp(req_susp), .req_resume(req_resume),
      .a(addr[MEM_AW-1:0]), .d(wdata), .lock(lock),
      .rd_word(rd_word), .busy(busy), .suspended(suspended),
      .prog_run(prog_run), .pbit7(pbit7), .esec(esec)
   );

   always_comb begin
      st_word     = '0;
      st_word[7]  = prog_run & ~pbit7;
      st_word[6]  = ~tog;
      sus_word    = '0;
      sus_word[6] = tog;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         tog   <= 1'b0;
      end else if (re) begin
         if (busy) begin
            rdata <= st_word;
            tog   <= ~tog;
         end else if (suspended && addr[MEM_AW-1:OFF_W] == esec) begin
            rdata <= sus_word;
         end else begin
            rdata <= rd_word;
         end
      end
   end

   assign ready = ~busy;

   // R10
   susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !ready && !prog_run && wdata[7:0] == K_SUSP) |=> ready);

   // R3
   erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re && !ready && !prog_run) |=> (rdata[7] == 1'b0));

endmodule

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;

   localparam int P   = 6;
   localparam int PRE = 10;
   localparam int ERS = 16;

   logic       clk = 1'b0;
   logic       rst_n, we, re, ready;
   logic [10:0] addr;
   logic [7:0] wdata, rdata;
   logic [3:0] lock;
   logic [7:0] mdl [64];
   int         nchk = 0, nerr = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   nor_cmd_ctrl #(.PROG_CYC(P), .PRE_CYC(PRE), .ERS_CYC(ERS)) u0 (
      .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
      .wdata(wdata), .lock(lock), .rdata(rdata), .ready(ready)
   );

   function automatic logic [7:0] exp_prog(input logic [7:0] old_w, input logic [7:0] new_w);
      return old_w & new_w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [10:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [10:0] a, output logic [7:0] d);
      re = 1'b1; addr = a;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic prog4(input logic [10:0] a, input logic [7:0] d);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
   endtask

   task automatic erase6(input logic [10:0] a);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(a, 8'h30);
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      logic [7:0] v, v2;
      int n;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
      rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0; lock = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 power-up state
      chk("R13 ready after reset", ready, 1);
      rd(11'd0, v);
      chk("R13 erased word", v, 8'hFF);

      // R1 R2 four-cycle program, busy window
      prog4(11'd8, 8'h0F); mdl[8] = 8'h0F;
      wait_ready(n);
      chk("R2 program busy cycles", n, P);
      rd(11'd8, v);
      chk("R1 programmed word", v, 8'h0F);
      prog4(11'd8, 8'hF5); mdl[8] = exp_prog(8'h0F, 8'hF5);
      wait_ready(n);
      rd(11'd8, v);
      chk("R1 AND of old and new", v, 8'h05);

      // R3 status polling during a program
      prog4(11'd9, 8'h7E); mdl[9] = 8'h7E;
      rd(11'd9, v);
      rd(11'd40, v2);
      chk("R3 poll bit7 complement", v[7], 1);
      chk("R3 toggle bit6 flips", v[6] ^ v2[6], 1);
      chk("R3 other status bits zero", {v[5:0], v2[5:0]}, 0);
      wait_ready(n);
      rd(11'd9, v);
      chk("R3 array data after op", v, 8'h7E);

      // R4 broken unlock sequences
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h100, 8'hA0); wr(11'd7, 8'h00);
      chk("R4 wrong third address no busy", ready, 1);
      wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'hA0); wr(11'd7, 8'h00);
      chk("R4 wrong second address no busy", ready, 1);
      rd(11'd7, v);
      chk("R4 word untouched", v, 8'hFF);

      // R13 0xF0 clears partial sequence
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hF0); wr(11'd7, 8'h00);
      chk("R13 clear code drops sequence", ready, 1);

      // R5 writes ignored while busy
      prog4(11'd11, 8'hC3); mdl[11] = 8'hC3;
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
      wait_ready(n);
      wr(11'd13, 8'h00);
      chk("R5 busy-time sequence not armed", ready, 1);
      rd(11'd13, v);
      chk("R5 word untouched", v, 8'hFF);

      // R6 bypass mode
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20);
      wr(11'd0, 8'hA0); wr(11'd10, 8'h3C); mdl[10] = 8'h3C;
      wait_ready(n);
      chk("R6 bypass program busy", n, P);
      rd(11'd10, v);
      chk("R6 bypass program data", v, 8'h3C);
      wr(11'd0, 8'h90); wr(11'd0, 8'h00);
      wr(11'd0, 8'hA0); wr(11'd14, 8'h00);
      chk("R6 exit leaves bypass", ready, 1);
      rd(11'd14, v);
      chk("R6 word after exit", v, 8'hFF);

      // R7 protected sector
      prog4(11'd20, 8'h11); mdl[20] = 8'h11;
      wait_ready(n);
      lock = 4'b0010;
      prog4(11'd20, 8'h00);
      chk("R7 locked program no busy", ready, 1);
      erase6(11'd22);
      chk("R7 locked erase no busy", ready, 1);
      rd(11'd20, v);
      chk("R7 locked word unchanged", v, 8'h11);
      lock = 4'b0000;

      // R8 R9 erase with pre-zeroing
      prog4(11'd33, 8'h12);
      wait_ready(n);
      erase6(11'd40);
      wait_ready(n);
      chk("R9 erase busy with pre-zero", n, PRE + ERS);
      for (int i = 32; i < 48; i++) begin
         rd(11'(i), v);
         chk("R8 sector erased", v, 8'hFF);
      end
      rd(11'd10, v);
      chk("R8 neighbour sector intact", v, 8'h3C);

      // R9 all-zero sector skips pre-zeroing
      for (int i = 32; i < 48; i++) begin
         prog4(11'(i), 8'h00);
         wait_ready(n);
      end
      erase6(11'd32);
      wait_ready(n);
      chk("R9 erase busy without pre-zero", n, ERS);
      rd(11'd47, v);
      chk("R9 zero sector erased", v, 8'hFF);

      // R10 R11 suspend and resume
      prog4(11'd50, 8'h55);
      wait_ready(n);
      erase6(11'd48);
      repeat (3) @(negedge clk);
      wr(11'd0, 8'hB0);
      chk("R10 ready high when suspended", ready, 1);
      rd(11'd50, v);
      chk("R10 suspended sector status", v & 8'hBF, 8'h00);
      rd(11'd10, v);
      chk("R10 other sector readable", v, 8'h3C);
      prog4(11'd12, 8'hA5); mdl[12] = 8'hA5;
      wait_ready(n);
      chk("R10 program during suspend busy", n, P);
      rd(11'd12, v);
      chk("R10 program during suspend data", v, 8'hA5);
      prog4(11'd52, 8'h00);
      chk("R10 suspended sector program ignored", ready, 1);
      wr(11'd0, 8'h30);
      chk("R11 resume drops ready", ready, 0);
      wait_ready(n);
      chk("R11 remaining erase bounded", (n > 0 && n <= PRE + ERS), 1);
      rd(11'd50, v);
      chk("R11 erase completed", v, 8'hFF);
      rd(11'd52, v);
      chk("R11 skipped program absent", v, 8'hFF);

      // R12 reset aborts program and leaves bypass
      prog4(11'd5, 8'h00);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R12 ready after abort", ready, 1);
      rd(11'd5, v);
      chk("R12 aborted program not stored", v, 8'hFF);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wr(11'd0, 8'hA0); wr(11'd6, 8'h00);
      chk("R12 reset leaves bypass", ready, 1);

      // R1 R6 random programs in sector 0
      for (int k = 0; k < 24; k++) begin
         logic [10:0] a;
         logic [7:0]  d;
         a = 11'($urandom_range(0, 15));
         d = 8'($urandom);
         if (k % 2 == 0) begin
            prog4(a, d);
         end else begin
            wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20);
            wr(11'd0, 8'hA0); wr(a, d);
         end
         mdl[a[5:0]] = exp_prog(mdl[a[5:0]], d);
         wait_ready(n);
         if (k % 2 == 1) begin
            wr(11'd0, 8'h90); wr(11'd0, 8'h00);
         end
         chk("R2 random busy", n, P);
         rd(a, v);
         chk("R1 random program", v, mdl[a[5:0]]);
      end

      // R8 R12 full array sweep against the model
      for (int i = 0; i < 64; i++) begin
         rd(11'(i), v);
         chk("R8 final array sweep", v, mdl[i]);
      end

      done = 1'b1;
      report();
   end

endmodule